// File: doc/BRIEF.md
# Predicated 16-bit Multicycle CPU Core

This block is a compact 16-bit processor that talks to a single word-addressed memory port. Its state is seven 16-bit registers reached by a 4-bit index: four general registers (0 to 3), a flag register (4), the program counter (5) and a stack pointer (6). Each instruction word is split into a 4-bit opcode in bits 15..12, a 3-bit condition in bits 11..9, a target index in bits 7..4 and a source index in bits 3..0. Bit 8 is ignored. Each instruction runs as a short sequence of states around one memory request at a time. A jump is simply a literal load into register 5.

Every instruction is conditional. When its condition does not hold, it leaves registers and memory untouched. The only exception is a literal move, which still consumes its trailing literal word so that decoding stays aligned. Stack operations name their pointer register as an operand, and the stack grows toward higher addresses. An illegal opcode or a reserved condition code stops the core. It then raises a sticky halt flag and makes no further memory requests until reset.

Top module: `predcore`

## Requirements
- R1: After a synchronous active-high reset, no memory strobe is active and halt is low. Register 6 holds 0x8000 and all other registers hold 0. The first request after reset is a read of address 0.
- R2: Condition code 0 (never) suppresses every register and memory effect of the instruction.
- R3: Condition codes are 1 = EQ set, 2 = LT or GT set, 3 = LT set, 4 = GT set and 7 = always. The flag bits are EQ = bit 0, LT = bit 1 and GT = bit 2 of register 4.
- R4: Opcode 0 loads the word that follows the instruction into the target register. The PC always steps past that literal, even when the condition fails. With target 5 the instruction is a jump.
- R5: Opcode 5 replaces the flag register with the unsigned comparison of source against target: EQ if they are equal, LT if source < target, GT if source > target.
- R6: Opcodes 3 (move source), 4 (add, modulo 2^16), 6 (bitwise and) and 7 (invert target) write their result into the target register.
- R7: Opcode 1 loads memory at the source register's address into the target register. Opcode 2 writes the source register to the address held in the target register.
- R8: Opcode 8 writes the source register to memory at the target register's address, then increments the target register. Opcode 9 decrements the target register, then loads memory at the new address into the source register.
- R9: Opcode A (call) writes the address of the word after the call to memory at the target register's address. It then increments the target register and loads the PC from the source register.
- R10: Opcodes B and C shift the source register right or left (logical shift) by the target register's value and write the result to the source register. A shift amount of 16 or more gives 0.
- R11: Opcodes D to F and condition codes 5 and 6 raise halt. Halt stays high until reset, and no strobe is issued while it is high.
- R12: The read and write strobes are never active together. A strobe, its address and its write data are held stable until a cycle in which ready is high, and the strobe drops in the next cycle.
- R13: Register indices 7 to 15 read as 0, and writes to them are discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 16 | Word address of the current request |
| mem_wdata | output | 16 | Write data |
| mem_rd | output | 1 | Read request strobe |
| mem_wr | output | 1 | Write request strobe |
| mem_rdata | input | 16 | Read data, valid while ready is high |
| mem_ready | input | 1 | Completes the pending request this cycle |
| halt | output | 1 | Sticky error stop |

## Verification
Two effects can meet in the same cycle. One is a completed memory handshake together with a register update that depends on it, such as the pointer increment after a push or call. The other is a second write that reads that same register, as in a call whose source and target are the same register, or a pop whose source is the PC. The bench provokes this with random ready stalls, including ready in the very first cycle of a strobe, and with directed call and return sequences. It judges the result by comparing the register values that the program dumps to memory against an instruction-level model written in the bench.

// File: rtl/predcore_pkg.sv
package predcore_pkg;
  localparam int DW     = 16;
  localparam int IW     = 4;
  localparam int NREGS  = 7;
  localparam int FR_IDX = 4;
  localparam int PC_IDX = 5;
  localparam int SP_IDX = 6;
  localparam int F_EQ   = 0;
  localparam int F_LT   = 1;
  localparam int F_GT   = 2;

  typedef enum logic [3:0] {
    OP_MOVL = 4'h0, OP_LOAD = 4'h1, OP_STORE = 4'h2, OP_MOV = 4'h3,
    OP_ADD  = 4'h4, OP_TST  = 4'h5, OP_AND   = 4'h6, OP_NOT = 4'h7,
    OP_PUSH = 4'h8, OP_POP  = 4'h9, OP_CALL  = 4'hA, OP_SHR = 4'hB,
    OP_SHL  = 4'hC, OP_BADD = 4'hD, OP_BADE  = 4'hE, OP_BADF = 4'hF
  } opcode_t;

  typedef struct packed {
    opcode_t      op;
    logic [2:0]   cond;
    logic         spare;
    logic [IW-1:0] tgt;
    logic [IW-1:0] src;
  } insn_t;

  typedef enum logic [2:0] {
    ST_FREQ, ST_FWAIT, ST_EXEC, ST_RWAIT, ST_WWAIT, ST_JMP, ST_POPRD, ST_HALT
  } state_t;
endpackage

// File: rtl/predcore_regs.sv
module predcore_regs import predcore_pkg::*; #(
  parameter logic [DW-1:0] SP_INIT = 16'h8000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [IW-1:0] ra_idx,
  output logic [DW-1:0] ra_data,
  input  logic [IW-1:0] rb_idx,
  output logic [DW-1:0] rb_data,
  input  logic          we,
  input  logic [IW-1:0] w_idx,
  input  logic [DW-1:0] w_data,
  output logic [DW-1:0] pc,
  output logic [2:0]    flags
);
  localparam int AW = $clog2(NREGS);
  logic [DW-1:0] regs [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    localparam logic [DW-1:0] RV = (g == SP_IDX) ? SP_INIT : '0;
    localparam logic [IW-1:0] GI = IW'(g);
    always_ff @(posedge clk) begin
      if (rst) regs[g] <= RV;
      else if (we && w_idx == GI) regs[g] <= w_data;
    end
  end

  assign ra_data = (ra_idx < IW'(NREGS)) ? regs[ra_idx[AW-1:0]] : '0;
  assign rb_data = (rb_idx < IW'(NREGS)) ? regs[rb_idx[AW-1:0]] : '0;
  assign pc      = regs[PC_IDX];
  assign flags   = regs[FR_IDX][2:0];
endmodule

// File: rtl/predcore_cond.sv
module predcore_cond import predcore_pkg::*; (
  input  logic [2:0] cond,
  input  logic [2:0] flags,
  output logic       pass,
  output logic       bad
);
  always_comb begin
    pass = 1'b0;
    bad  = 1'b0;
    case (cond)
      3'd0: pass = 1'b0;
      3'd1: pass = flags[F_EQ];
      3'd2: pass = flags[F_LT] | flags[F_GT];
      3'd3: pass = flags[F_LT];
      3'd4: pass = flags[F_GT];
      3'd7: pass = 1'b1;
      default: bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/predcore_alu.sv
module predcore_alu import predcore_pkg::*; (
  input  opcode_t       op,
  input  logic [DW-1:0] tv,
  input  logic [DW-1:0] sv,
  output logic [DW-1:0] res,
  output logic [2:0]    cmp
);
  always_comb begin
    case (op)
      OP_ADD:  res = tv + sv;
      OP_AND:  res = tv & sv;
      OP_NOT:  res = ~tv;
      OP_SHR:  res = sv >> tv;
      OP_SHL:  res = sv << tv;
      default: res = sv;
    endcase
    cmp        = '0;
    cmp[F_EQ]  = (sv == tv);
    cmp[F_LT]  = (sv < tv);
    cmp[F_GT]  = (sv > tv);
  end
endmodule

// File: rtl/predcore.sv
module predcore import predcore_pkg::*; #(
  parameter logic [DW-1:0] SP_INIT = 16'h8000
) (
  input  logic          clk,
  input  logic          rst,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_rd,
  output logic          mem_wr,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ready,
  output logic          halt
);
  state_t        state;
  insn_t         ir;
  logic [IW-1:0] ld_idx;
  logic          ld_en, post_inc, post_jmp;
  logic [DW-1:0] rt, rs, pc, alu_res;
  logic [2:0]    flags, cmp;
  logic          pass, bad_cond, bad;
  logic          we;
  logic [IW-1:0] w_idx;
  logic [DW-1:0] w_data;
  logic          unused_spare;

  assign unused_spare = ir.spare;

  predcore_regs #(.SP_INIT(SP_INIT)) u_regs (
    .clk(clk), .rst(rst),
    .ra_idx(ir.tgt), .ra_data(rt),
    .rb_idx(ir.src), .rb_data(rs),
    .we(we), .w_idx(w_idx), .w_data(w_data),
    .pc(pc), .flags(flags)
  );

  predcore_cond u_cond (.cond(ir.cond), .flags(flags), .pass(pass), .bad(bad_cond));

  predcore_alu u_alu (.op(ir.op), .tv(rt), .sv(rs), .res(alu_res), .cmp(cmp));

  assign bad = bad_cond || (ir.op > OP_SHL);

  // single register write port, steered by the sequencer state
  always_comb begin
    we     = 1'b0;
    w_idx  = ir.tgt;
    w_data = alu_res;
    case (state)
      ST_FWAIT: if (mem_ready) begin
        we = 1'b1; w_idx = IW'(PC_IDX); w_data = pc + 1'b1;
      end
      ST_EXEC: if (!bad) begin
        case (ir.op)
          OP_MOVL: begin we = 1'b1; w_idx = IW'(PC_IDX); w_data = pc + 1'b1; end
          OP_MOV, OP_ADD, OP_AND, OP_NOT: we = pass;
          OP_SHR, OP_SHL: begin we = pass; w_idx = ir.src; end
          OP_TST: begin we = pass; w_idx = IW'(FR_IDX); w_data = {{(DW-3){1'b0}}, cmp}; end
          OP_POP: begin we = pass; w_data = rt - 1'b1; end
          default: we = 1'b0;
        endcase
      end
      ST_RWAIT: if (mem_ready && ld_en) begin
        we = 1'b1; w_idx = ld_idx; w_data = mem_rdata;
      end
      ST_WWAIT: if (mem_ready && post_inc) begin
        we = 1'b1; w_data = rt + 1'b1;
      end
      ST_JMP: begin we = 1'b1; w_idx = IW'(PC_IDX); w_data = rs; end
      default: we = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_FREQ;
      ir        <= '0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_rd    <= 1'b0;
      mem_wr    <= 1'b0;
      halt      <= 1'b0;
      ld_idx    <= '0;
      ld_en     <= 1'b0;
      post_inc  <= 1'b0;
      post_jmp  <= 1'b0;
    end else begin
      case (state)
        ST_FREQ: begin
          mem_rd <= 1'b1; mem_addr <= pc; state <= ST_FWAIT;
        end
        ST_FWAIT: if (mem_ready) begin
          mem_rd <= 1'b0; ir <= insn_t'(mem_rdata); state <= ST_EXEC;
        end
        ST_EXEC: begin
          state <= ST_FREQ;
          if (bad) begin
            halt <= 1'b1; state <= ST_HALT;
          end else begin
            case (ir.op)
              OP_MOVL: begin
                mem_rd <= 1'b1; mem_addr <= pc; ld_en <= pass; ld_idx <= ir.tgt;
                state <= ST_RWAIT;
              end
              OP_LOAD: if (pass) begin
                mem_rd <= 1'b1; mem_addr <= rs; ld_en <= 1'b1; ld_idx <= ir.tgt;
                state <= ST_RWAIT;
              end
              OP_STORE, OP_PUSH, OP_CALL: if (pass) begin
                mem_wr    <= 1'b1;
                mem_addr  <= rt;
                mem_wdata <= (ir.op == OP_CALL) ? pc : rs;
                post_inc  <= (ir.op != OP_STORE);
                post_jmp  <= (ir.op == OP_CALL);
                state     <= ST_WWAIT;
              end
              OP_POP: if (pass) state <= ST_POPRD;
              default: state <= ST_FREQ;
            endcase
          end
        end
        ST_POPRD: begin
          mem_rd <= 1'b1; mem_addr <= rt; ld_en <= 1'b1; ld_idx <= ir.src;
          state <= ST_RWAIT;
        end
        ST_RWAIT: if (mem_ready) begin
          mem_rd <= 1'b0; state <= ST_FREQ;
        end
        ST_WWAIT: if (mem_ready) begin
          mem_wr <= 1'b0; state <= post_jmp ? ST_JMP : ST_FREQ;
        end
        ST_JMP:  state <= ST_FREQ;
        default: state <= ST_HALT;
      endcase
    end
  end
endmodule

// File: rtl/predcore_chk.sv
module predcore_chk (
  input logic        clk,
  input logic        rst,
  input logic [15:0] mem_addr,
  input logic [15:0] mem_wdata,
  input logic        mem_rd,
  input logic        mem_wr,
  input logic        mem_ready,
  input logic        halt
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!mem_rd && !mem_wr && !halt));

  // R12
  one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  // R12
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && !mem_ready) |=> (mem_rd && $stable(mem_addr)));

  // R12
  wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_wr && !mem_ready) |=> (mem_wr && $stable(mem_addr) && $stable(mem_wdata)));

  // R12
  rd_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && mem_ready) |=> !mem_rd);

  // R12
  wr_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_wr && mem_ready) |=> !mem_wr);

  // R11
  halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    halt |=> halt);

  // R11
  halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    halt |-> (!mem_rd && !mem_wr));
endmodule

bind predcore predcore_chk u_chk (
  .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_ready(mem_ready), .halt(halt)
);

// File: tb/predcore_tb.sv
module predcore_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_rd, mem_wr, mem_ready, halt;

  predcore u_dut (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready), .halt(halt)
  );

  logic [15:0] mem  [logic [15:0]];
  logic [15:0] refm [logic [15:0]];
  int checks = 0, errs = 0, proto_err = 0, ap = 0, cycles = 0;

  logic        sn_rd = 0, sn_wr = 0, sn_rdy = 0;
  logic [15:0] sn_addr = 0, sn_wdata = 0;

  function automatic logic [15:0] mget(logic [15:0] a);
    return mem.exists(a) ? mem[a] : 16'h0;
  endfunction
  function automatic logic [15:0] rget(logic [15:0] a);
    return refm.exists(a) ? refm[a] : 16'h0;
  endfunction
  function automatic logic [15:0] enc(int op, int cd, int t, int s);
    return {op[3:0], cd[2:0], 1'b0, t[3:0], s[3:0]};
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // memory model: random ready, data presented at negedge, write on posedge
  initial mem_ready = 1'b0;
  initial mem_rdata = 16'h0;
  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      if (sn_rd && !sn_rdy && !(mem_rd && mem_addr == sn_addr)) proto_err++;
      if (sn_wr && !sn_rdy && !(mem_wr && mem_addr == sn_addr && mem_wdata == sn_wdata)) proto_err++;
      if (mem_rd && mem_wr) proto_err++;
    end
    mem_ready = ($urandom_range(3) != 0);
    mem_rdata = mget(mem_addr);
    sn_rd = mem_rd; sn_wr = mem_wr; sn_rdy = mem_ready;
    sn_addr = mem_addr; sn_wdata = mem_wdata;
  end
  always @(posedge clk) if (!rst && mem_wr && mem_ready) mem[mem_addr] = mem_wdata;

  // program construction
  task automatic prog_begin();
    mem.delete(); refm.delete(); ap = 0;
  endtask
  task automatic emit(logic [15:0] w);
    mem[ap[15:0]] = w; refm[ap[15:0]] = w; ap++;
  endtask
  task automatic movl(int cd, int t, int lit);
    emit(enc(0, cd, t, 0)); emit(lit[15:0]);
  endtask
  task automatic dump_and_stop();
    movl(7, 3, 16'h200);
    emit(enc(8, 7, 3, 0)); emit(enc(8, 7, 3, 1)); emit(enc(8, 7, 3, 2));
    emit(enc(8, 7, 3, 4)); emit(enc(8, 7, 3, 6));
    emit(16'hF000);
  endtask

  // instruction-level reference model
  task automatic model_run(output bit halted);
    logic [15:0] r [7];
    logic [15:0] w, vt, vs, lit;
    logic [3:0]  op, t, s;
    logic [2:0]  cd, f;
    bit          pass;
    for (int i = 0; i < 7; i++) r[i] = 16'h0;
    r[6] = 16'h8000;
    halted = 0;
    for (int n = 0; n < 4000 && !halted; n++) begin
      w = rget(r[5]); r[5] = r[5] + 1;
      op = w[15:12]; cd = w[11:9]; t = w[7:4]; s = w[3:0];
      f = r[4][2:0];
      if (op > 4'hC || cd == 3'd5 || cd == 3'd6) halted = 1;
      else begin
        case (cd)
          3'd0: pass = 0;
          3'd1: pass = f[0];
          3'd2: pass = f[1] | f[2];
          3'd3: pass = f[1];
          3'd4: pass = f[2];
          default: pass = 1;
        endcase
        vt = (t < 7) ? r[t[2:0]] : 16'h0;
        vs = (s < 7) ? r[s[2:0]] : 16'h0;
        if (op == 4'h0) begin
          lit = rget(r[5]); r[5] = r[5] + 1;
          if (pass && t < 7) r[t[2:0]] = lit;
        end else if (pass) begin
          case (op)
            4'h1: if (t < 7) r[t[2:0]] = rget(vs);
            4'h2: refm[vt] = vs;
            4'h3: if (t < 7) r[t[2:0]] = vs;
            4'h4: if (t < 7) r[t[2:0]] = vt + vs;
            4'h5: r[4] = {13'h0, (vs > vt), (vs < vt), (vs == vt)};
            4'h6: if (t < 7) r[t[2:0]] = vt & vs;
            4'h7: if (t < 7) r[t[2:0]] = ~vt;
            4'h8: begin refm[vt] = vs; if (t < 7) r[t[2:0]] = vt + 1; end
            4'h9: begin
              if (t < 7) r[t[2:0]] = vt - 1;
              vt = (t < 7) ? r[t[2:0]] : 16'h0;
              if (s < 7) r[s[2:0]] = rget(vt);
            end
            4'hA: begin
              refm[vt] = r[5];
              if (t < 7) r[t[2:0]] = vt + 1;
              r[5] = (s < 7) ? r[s[2:0]] : 16'h0;
            end
            4'hB: if (s < 7) r[s[2:0]] = vs >> vt;
            default: if (s < 7) r[s[2:0]] = vs << vt;
          endcase
        end
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state of the outputs
    chk(!mem_rd && !mem_wr && !halt, "R1", "strobes/halt in reset",
        {mem_rd, mem_wr, halt}, 0);
    rst = 1'b0;
    @(negedge clk);
    // R1 first request is a read of address 0
    chk(mem_rd && !mem_wr && mem_addr == 16'h0, "R1", "first fetch",
        {mem_rd, mem_wr, mem_addr}, 32'h20000);
  endtask

  task automatic run_prog(string name, bit expect_halt_only);
    bit mh;
    proto_err = 0;
    do_reset();
    for (int c = 0; c < 20000 && !halt; c++) @(negedge clk);
    model_run(mh);
    chk(halt && mh, "R11", {name, " halted"}, halt, 1);
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      // R11 sticky and silent
      chk(halt && !mem_rd && !mem_wr, "R11", {name, " quiet after halt"},
          {halt, mem_rd, mem_wr}, 3'b100);
    end
    for (int i = 0; i < 5; i++) begin
      logic [15:0] a;
      a = 16'h200 + 16'(i);
      chk(mget(a) == rget(a), expect_halt_only ? "R11" : "R2",
          {name, " dump vs model"}, mget(a), rget(a));
    end
    // R12 handshake discipline observed at the ports
    chk(proto_err == 0, "R12", {name, " handshake"}, proto_err, 0);
  endtask

  function automatic int pick_cond();
    case ($urandom_range(7))
      0: return 0; 1: return 1; 2: return 2; 3: return 3; 4: return 4;
      default: return 7;
    endcase
  endfunction
  function automatic int pick_w();
    case ($urandom_range(3))
      0: return 0; 1: return 1; 2: return 2; default: return 4;
    endcase
  endfunction

  initial begin : watchdog
    wait (cycles > 150000);
    errs++; checks++;
    $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cycles);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd4242));

    // D1: reset values of SP and a general register
    prog_begin();
    movl(7, 0, 16'h100); emit(enc(2, 7, 0, 6));
    movl(7, 2, 16'h101); emit(enc(2, 7, 2, 1));
    dump_and_stop();
    run_prog("reset", 0);
    chk(mget(16'h100) == 16'h8000, "R1", "SP reset", mget(16'h100), 16'h8000);
    chk(mget(16'h101) == 16'h0, "R1", "r1 reset", mget(16'h101), 0);
    chk(mget(16'h101) == 16'h0, "R7", "store of r1", mget(16'h101), 0);

    // D2: literal skip under never, jump over a literal move
    prog_begin();
    movl(0, 1, 16'h2222);
    movl(7, 0, 16'h1111);
    movl(7, 5, ap + 4);
    movl(7, 2, 16'hDEAD);
    dump_and_stop();
    run_prog("literal", 0);
    chk(mget(16'h200) == 16'h1111, "R4", "literal skipped when never", mget(16'h200), 16'h1111);
    chk(mget(16'h201) == 16'h0, "R2", "never has no effect", mget(16'h201), 0);
    chk(mget(16'h202) == 16'h0, "R4", "jump skips move", mget(16'h202), 0);

    // D3: compare and every condition
    prog_begin();
    movl(7, 0, 5); movl(7, 1, 9);
    emit(enc(5, 7, 1, 0));
    movl(1, 0, 16'hAAAA); movl(2, 1, 16'h42); movl(3, 2, 16'h33); movl(4, 2, 16'h44);
    movl(7, 3, 16'h210); emit(enc(2, 7, 3, 1));
    movl(7, 3, 16'h211); emit(enc(2, 7, 3, 2));
    movl(7, 3, 16'h212); emit(enc(2, 7, 3, 4));
    movl(7, 0, 9); movl(7, 1, 5);
    emit(enc(5, 7, 1, 0)); movl(4, 2, 16'h44);
    emit(enc(5, 7, 0, 0)); movl(1, 1, 16'h55);
    dump_and_stop();
    run_prog("conds", 0);
    chk(mget(16'h210) == 16'h42, "R3", "NE taken on LT", mget(16'h210), 16'h42);
    chk(mget(16'h211) == 16'h33, "R3", "LT taken, GT not", mget(16'h211), 16'h33);
    chk(mget(16'h212) == 16'h2, "R5", "LT flag value", mget(16'h212), 2);
    chk(mget(16'h202) == 16'h44, "R3", "GT taken", mget(16'h202), 16'h44);
    chk(mget(16'h201) == 16'h55, "R3", "EQ taken", mget(16'h201), 16'h55);
    chk(mget(16'h203) == 16'h1, "R5", "EQ flag only", mget(16'h203), 1);

    // D4: call, return by pop into PC, load
    prog_begin();
    movl(7, 1, 16'h300);
    movl(7, 2, 9);
    emit(enc(10, 7, 1, 2));
    movl(7, 0, 16'h1234);
    movl(7, 5, 12);
    movl(7, 0, 16'h77);
    emit(enc(9, 7, 1, 5));
    movl(7, 2, 16'h300);
    emit(enc(1, 7, 2, 2));
    dump_and_stop();
    run_prog("call", 0);
    chk(mget(16'h300) == 16'h5, "R9", "return address saved", mget(16'h300), 5);
    chk(mget(16'h200) == 16'h1234, "R9", "return path", mget(16'h200), 16'h1234);
    chk(mget(16'h201) == 16'h300, "R8", "pop restores pointer", mget(16'h201), 16'h300);
    chk(mget(16'h202) == 16'h5, "R7", "load", mget(16'h202), 5);
    chk(mget(16'h204) == 16'h8000, "R8", "push of SP", mget(16'h204), 16'h8000);

    // D5: shifts
    prog_begin();
    movl(7, 0, 16'h8001); movl(7, 1, 4);
    emit(enc(11, 7, 1, 0));
    movl(7, 2, 16);
    emit(enc(12, 7, 2, 1));
    dump_and_stop();
    run_prog("shift", 0);
    chk(mget(16'h200) == 16'h0800, "R10", "shift right", mget(16'h200), 16'h0800);
    chk(mget(16'h201) == 16'h0, "R10", "shift left by 16", mget(16'h201), 0);

    // D6: reserved condition and illegal opcode
    prog_begin();
    movl(7, 0, 1); emit(enc(4, 5, 0, 0)); dump_and_stop();
    run_prog("cond5", 1);
    chk(mget(16'h200) == 16'h0, "R11", "no execution past reserved cond", mget(16'h200), 0);
    prog_begin();
    movl(7, 0, 1); emit(16'hD000); dump_and_stop();
    run_prog("opD", 1);
    chk(mget(16'h200) == 16'h0, "R11", "no execution past opcode D", mget(16'h200), 0);

    // D7: out-of-range register indices
    prog_begin();
    movl(7, 0, 16'h1234); movl(7, 1, 16'h77);
    movl(7, 9, 16'h5555);
    emit(enc(3, 7, 1, 9)); emit(enc(3, 7, 0, 14));
    dump_and_stop();
    run_prog("index", 0);
    chk(mget(16'h200) == 16'h0, "R13", "index 14 reads 0", mget(16'h200), 0);
    chk(mget(16'h201) == 16'h0, "R13", "index 9 write dropped", mget(16'h201), 0);

    // D8: add wrap, invert, and
    prog_begin();
    movl(7, 0, 16'hFFFF); movl(7, 1, 2);
    emit(enc(4, 7, 0, 1)); emit(enc(7, 7, 1, 0)); emit(enc(6, 7, 1, 0));
    dump_and_stop();
    run_prog("alu", 0);
    chk(mget(16'h200) == 16'h1, "R6", "add wraps", mget(16'h200), 1);
    chk(mget(16'h201) == 16'h1, "R6", "not then and", mget(16'h201), 1);

    // random programs against the model (R2 R3 R5 R6 R10)
    for (int p = 0; p < 6; p++) begin
      prog_begin();
      for (int k = 0; k < 24; k++) begin
        case ($urandom_range(7))
          0: movl(pick_cond(), pick_w(), $urandom_range(16'hFFFF));
          1: emit(enc(3, pick_cond(), pick_w(), $urandom_range(4)));
          2: emit(enc(4, pick_cond(), pick_w(), $urandom_range(4)));
          3: emit(enc(5, pick_cond(), $urandom_range(3), $urandom_range(3)));
          4: emit(enc(6, pick_cond(), pick_w(), $urandom_range(4)));
          5: emit(enc(7, pick_cond(), pick_w(), 0));
          6: emit(enc(11, pick_cond(), $urandom_range(4), pick_w()));
          default: emit(enc(12, pick_cond(), $urandom_range(4), pick_w()));
        endcase
      end
      dump_and_stop();
      run_prog("random", 0);
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule